// File: doc/BRIEF.md
# Acquisition Sample Ring Buffer

This block is a circular store for 16-bit converted samples, placed between an ADC producer and a host that drains it over a simple word-wide register bus. The producer presents one sample per cycle with a valid strobe. The block writes the sample at the write (head) index and moves the head forward. The host reads sample words straight out of the store by address. When it has consumed them, it writes its new read (tail) index into a dedicated register. The store depth is not a power of two (2003 by default), so both indices return to zero by comparison with the depth and not by truncating bits.

The block keeps eight sticky event flags and an eight-bit enable mask, and drives one interrupt request. Three sources set flags. The fill flag rises while the number of stored samples is at or above a programmable fill level. The drop flag rises when a sample arrives while the store is full. The other flags come from external event pulses. The host clears flags by writing ones to them.

Top module: `acq_ring_top`

## Requirements
- R1: After synchronous reset the head, tail and mask read 0, the flags read 0, the fill level reads DEPTH/2 (1001) and `irq` is low.
- R2: A sample presented with `smp_valid` while the store is not full is written at the head index, and the head advances by one. From DEPTH-1 the head returns to 0.
- R3: The store is full when head+1 equals the tail, modulo DEPTH. A sample presented while full is dropped, the head keeps its value, and flag bit 1 (drop) is set.
- R4: The fill register (address 0xFF5) reads head minus tail, with DEPTH added when that difference is negative.
- R5: A write to the tail register (0xFF1) with a value below DEPTH replaces the tail. A value of DEPTH or more is ignored. Writes to the head register (0xFF0) have no effect.
- R6: While the fill count is at or above the fill level (register 0xFF4), flag bit 0 is set on the next clock edge.
- R7: Flags (register 0xFF3) stay set until the host writes 1 to that bit position. A set condition in the same cycle wins over the clear, so bit 0 comes back while the fill count stays at or above the level.
- R8: A one-cycle pulse on `ext_evt[k]` sets flag bit k.
- R9: `irq` is high exactly when some flag bit is set whose mask bit (register 0xFF2) is also set. A mask of 0 keeps `irq` low.
- R10: A read strobe at an address below DEPTH returns the stored sample on `bus_rdata` in the cycle after the strobe. Register addresses return their value zero-extended to 16 bits, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Producer sample strobe |
| smp_data | input | 16 | Producer sample word |
| ext_evt | input | 8 | Event pulses that set the matching flag bits |
| bus_addr | input | 12 | Host word address |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, valid the cycle after `bus_re` |
| irq | output | 1 | Interrupt request |

## Verification
A head or tail index that wraps at the wrong value shows up on the very next host read. The index register or the fill register then reads beyond DEPTH-1, or the word read back from the slot just below the head is not the sample last pushed. A faulty full comparison either accepts one sample too many, so the head lands on the tail and the fill count reads 0, or it drops samples early, and the drop flag appears. A fault in the flag or mask logic is seen on `irq` one cycle after the flag register changes, and on the flag register at the next read.

// File: rtl/acq_ring_pkg.sv
package acq_ring_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int NFLAG  = 8;

    localparam logic [ADDR_W-1:0] RA_HEAD  = 12'hFF0;
    localparam logic [ADDR_W-1:0] RA_TAIL  = 12'hFF1;
    localparam logic [ADDR_W-1:0] RA_MASK  = 12'hFF2;
    localparam logic [ADDR_W-1:0] RA_FLAGS = 12'hFF3;
    localparam logic [ADDR_W-1:0] RA_LEVEL = 12'hFF4;
    localparam logic [ADDR_W-1:0] RA_FILL  = 12'hFF5;

    typedef enum int {
        FL_FILL  = 0,
        FL_DROP  = 1
    } flag_pos_e;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] ring_next(input logic [DATA_W-1:0] p,
                                                    input logic [DATA_W-1:0] depth);
        return (p == depth - 16'd1) ? 16'd0 : p + 16'd1;
    endfunction

    function automatic logic [DATA_W-1:0] ring_fill(input logic [DATA_W-1:0] head,
                                                    input logic [DATA_W-1:0] tail,
                                                    input logic [DATA_W-1:0] depth);
        return (head >= tail) ? (head - tail) : (head + depth - tail);
    endfunction

endpackage

// File: rtl/acq_ring_ptrs.sv
module acq_ring_ptrs
    import acq_ring_pkg::*;
#(
    parameter int DEPTH = 2003
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic              tail_wr,
    input  logic [DATA_W-1:0] tail_wdata,
    output logic [DATA_W-1:0] head_q,
    output logic [DATA_W-1:0] tail_q,
    output logic              full,
    output logic              accept,
    output logic              drop
);
    localparam logic [DATA_W-1:0] DEPTH_W = DATA_W'(DEPTH);

    logic [DATA_W-1:0] head_nxt;

    always_comb begin
        head_nxt = ring_next(head_q, DEPTH_W);
        full     = (head_nxt == tail_q);
        accept   = smp_valid && !full;
        drop     = smp_valid && full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (accept) head_q <= head_nxt;
            if (tail_wr && (tail_wdata < DEPTH_W)) tail_q <= tail_wdata;
        end
    end
endmodule

// File: rtl/acq_ring_flags.sv
module acq_ring_flags
    import acq_ring_pkg::*;
#(
    parameter int LEVEL_RST = 1001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] fill,
    input  logic              drop,
    input  logic [NFLAG-1:0]  ext_evt,
    input  logic              flag_wr,
    input  logic              mask_wr,
    input  logic              level_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NFLAG-1:0]  flags_q,
    output logic [NFLAG-1:0]  mask_q,
    output logic [DATA_W-1:0] level_q,
    output logic              irq
);
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] clr_vec;

    always_comb begin
        set_vec          = ext_evt;
        set_vec[FL_FILL] = ext_evt[FL_FILL] | (fill >= level_q);
        set_vec[FL_DROP] = ext_evt[FL_DROP] | drop;
        clr_vec          = flag_wr ? wdata[NFLAG-1:0] : '0;
        irq              = |(flags_q & mask_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            mask_q  <= '0;
            level_q <= DATA_W'(LEVEL_RST);
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            if (mask_wr)  mask_q  <= wdata[NFLAG-1:0];
            if (level_wr) level_q <= wdata;
        end
    end
endmodule

// File: rtl/acq_ring_store.sv
module acq_ring_store
    import acq_ring_pkg::*;
#(
    parameter int DEPTH = 2003,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
        if (rd_en) rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/acq_ring_top.sv
module acq_ring_top
    import acq_ring_pkg::*;
#(
    parameter int DEPTH     = 2003,
    parameter int LEVEL_RST = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [15:0]       smp_data,
    input  logic [7:0]        ext_evt,
    input  logic [11:0]       bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [DATA_W-1:0] DEPTH_W = DATA_W'(DEPTH);

    bus_req_t          req;
    logic [DATA_W-1:0] head_q, tail_q, fill, level_q, mem_q, reg_q;
    logic [NFLAG-1:0]  flags_q, mask_q;
    logic              full, accept, drop;
    logic              tail_wr, flag_wr, mask_wr, level_wr;
    logic              is_mem, rd_mem_q;
    logic [DATA_W-1:0] reg_sel;

    always_comb begin
        req       = '{we: bus_we, re: bus_re, addr: bus_addr, wdata: bus_wdata};
        tail_wr   = req.we && (req.addr == RA_TAIL);
        flag_wr   = req.we && (req.addr == RA_FLAGS);
        mask_wr   = req.we && (req.addr == RA_MASK);
        level_wr  = req.we && (req.addr == RA_LEVEL);
        is_mem    = (DATA_W'(req.addr) < DEPTH_W);
        fill      = ring_fill(head_q, tail_q, DEPTH_W);
        unique case (req.addr)
            RA_HEAD:  reg_sel = head_q;
            RA_TAIL:  reg_sel = tail_q;
            RA_MASK:  reg_sel = DATA_W'(mask_q);
            RA_FLAGS: reg_sel = DATA_W'(flags_q);
            RA_LEVEL: reg_sel = level_q;
            RA_FILL:  reg_sel = fill;
            default:  reg_sel = '0;
        endcase
    end

    acq_ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .tail_wr(tail_wr), .tail_wdata(req.wdata),
        .head_q(head_q), .tail_q(tail_q),
        .full(full), .accept(accept), .drop(drop)
    );

    acq_ring_flags #(.LEVEL_RST(LEVEL_RST)) u_flags (
        .clk(clk), .rst(rst), .fill(fill), .drop(drop), .ext_evt(ext_evt),
        .flag_wr(flag_wr), .mask_wr(mask_wr), .level_wr(level_wr),
        .wdata(req.wdata), .flags_q(flags_q), .mask_q(mask_q),
        .level_q(level_q), .irq(irq)
    );

    acq_ring_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_en(accept), .wr_idx(head_q[IDX_W-1:0]), .wr_data(smp_data),
        .rd_en(req.re && is_mem), .rd_idx(req.addr[IDX_W-1:0]), .rd_data(mem_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_mem_q <= 1'b0;
            reg_q    <= '0;
        end else if (req.re) begin
            rd_mem_q <= is_mem;
            reg_q    <= is_mem ? '0 : reg_sel;
        end
    end

    assign bus_rdata = rd_mem_q ? mem_q : reg_q;
endmodule

// File: rtl/acq_ring_chk.sv
module acq_ring_chk
    import acq_ring_pkg::*;
#(
    parameter int DEPTH = 2003
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic              full,
    input logic [DATA_W-1:0] head_q,
    input logic [DATA_W-1:0] tail_q,
    input logic [DATA_W-1:0] fill,
    input logic [DATA_W-1:0] level_q,
    input logic [NFLAG-1:0]  flags_q,
    input logic [NFLAG-1:0]  mask_q,
    input logic              tail_wr,
    input logic              flag_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq
);
    localparam logic [DATA_W-1:0] DW = DATA_W'(DEPTH);

    assert_head_range_R2: assert property (@(posedge clk) disable iff (rst)
        head_q < DW);

    assert_head_step_R2: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !full) |=>
        head_q == (($past(head_q) == DW - 16'd1) ? 16'd0 : $past(head_q) + 16'd1));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && full) |=> ($stable(head_q) && flags_q[FL_DROP]));

    assert_tail_ignore_R5: assert property (@(posedge clk) disable iff (rst)
        (tail_wr && bus_wdata >= DW) |=> $stable(tail_q));

    assert_fill_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (fill >= level_q) |=> flags_q[FL_FILL]);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flags_q[7] && !(flag_wr && bus_wdata[7])) |=> flags_q[7]);

    assert_mask_off_R9: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);
endmodule

bind acq_ring_top acq_ring_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .full(full),
    .head_q(head_q), .tail_q(tail_q), .fill(fill), .level_q(level_q),
    .flags_q(flags_q), .mask_q(mask_q), .tail_wr(tail_wr), .flag_wr(flag_wr),
    .bus_wdata(bus_wdata), .irq(irq)
);

// File: tb/test_acq_ring_top.sv
`timescale 1ns/1ps
module test_acq_ring_top;
    localparam int DEPTH = 2003;
    localparam logic [11:0] A_HEAD = 12'hFF0, A_TAIL = 12'hFF1, A_MASK = 12'hFF2,
                            A_FLAGS = 12'hFF3, A_LEVEL = 12'hFF4, A_FILL = 12'hFF5;

    // op (0 push n, 1 tail write), argument, expected head, expected fill
    localparam int NVEC = 7;
    localparam int VEC [NVEC][4] = '{
        '{0, 3,    3,  3},
        '{1, 2,    3,  1},
        '{0, 10,   13, 11},
        '{1, 13,   13, 0},
        '{1, 2500, 13, 0},
        '{0, 1990, 0,  1990},
        '{1, 1995, 0,  8}
    };

    logic clk = 0, rst = 1, smp_valid = 0, bus_we = 0, bus_re = 0, irq;
    logic [15:0] smp_data = 0, bus_wdata = 0, bus_rdata;
    logic [7:0]  ext_evt = 0;
    logic [11:0] bus_addr = 0;
    int total = 0, bad = 0;
    logic [15:0] seq = 16'h1000, last = 0, rv = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    acq_ring_top i_acq_ring_top (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .ext_evt(ext_evt), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk); bus_re = 1; bus_addr = a;
        @(negedge clk); bus_re = 0; d = bus_rdata;
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); smp_valid = 1; smp_data = seq; last = seq; seq = seq + 1;
        end
        @(negedge clk); smp_valid = 0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        rd(A_HEAD, rv);  check("R1 head", rv, 0);
        rd(A_TAIL, rv);  check("R1 tail", rv, 0);
        rd(A_MASK, rv);  check("R1 mask", rv, 0);
        rd(A_FLAGS, rv); check("R1 flags", rv, 0);
        rd(A_LEVEL, rv); check("R1 level", rv, 1001);
        check("R1 irq", irq, 0);

        // vector walk: R2 R4 R5 R10
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][0] == 0) begin
                push(VEC[v][1]);
                rd(12'((VEC[v][2] + DEPTH - 1) % DEPTH), rv);
                check("R10 slot below head", rv, last);
            end else begin
                wr(A_TAIL, 16'(VEC[v][1]));
            end
            rd(A_HEAD, rv); check("R2 head", rv, VEC[v][2]);
            rd(A_FILL, rv); check("R4 fill", rv, VEC[v][3]);
        end
        rd(12'hF00, rv); check("R10 unmapped", rv, 0);

        // R6 R7 R9: level, sticky clear, reassert
        do_reset();
        wr(A_LEVEL, 4); wr(A_MASK, 1);
        push(3);
        rd(A_FLAGS, rv); check("R6 below level", rv, 0);
        check("R9 irq low", irq, 0);
        push(1);
        rd(A_FLAGS, rv); check("R6 at level", rv, 1);
        check("R9 irq high", irq, 1);
        wr(A_FLAGS, 1);
        rd(A_FLAGS, rv); check("R7 reassert", rv, 1);
        wr(A_TAIL, 4); wr(A_FLAGS, 1);
        rd(A_FLAGS, rv); check("R7 cleared", rv, 0);
        check("R9 irq after clear", irq, 0);

        // R8 R9 external event and mask
        @(negedge clk); ext_evt = 8'h80;
        @(negedge clk); ext_evt = 0;
        rd(A_FLAGS, rv); check("R8 event flag", rv, 8'h80);
        check("R9 masked off", irq, 0);
        wr(A_MASK, 16'h80); @(negedge clk);
        check("R9 unmasked", irq, 1);
        wr(A_FLAGS, 16'h80);
        rd(A_FLAGS, rv); check("R7 w1c bit7", rv, 0);
        wr(A_MASK, 16'hFF); wr(A_MASK, 0);
        @(negedge clk); ext_evt = 8'h04;
        @(negedge clk); ext_evt = 0;
        @(negedge clk); check("R9 mask zero", irq, 0);

        // R5 head register not writable
        wr(A_HEAD, 77);
        rd(A_HEAD, rv); check("R5 head write ignored", rv, 4);

        // R3 full and drop
        do_reset();
        push(DEPTH - 1);
        rd(A_FILL, rv);  check("R3 fill at full", rv, DEPTH - 1);
        rd(A_FLAGS, rv); check("R3 no drop yet", rv[1], 0);
        push(1);
        rd(A_HEAD, rv);  check("R3 head held", rv, DEPTH - 1);
        rd(A_FLAGS, rv); check("R3 drop flag", rv[1], 1);
        wr(A_TAIL, 5);
        push(6);
        rd(A_HEAD, rv);  check("R3 head after wrap", rv, 4);
        rd(A_FILL, rv);  check("R4 fill wrapped", rv, DEPTH - 1);
        rd(12'd0, rv);   check("R2 slot 0 data", rv, last - 16'd4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule